// File: doc/BRIEF.md
# Masked-Write GPIO Port

This block is a 32-pin general-purpose I/O port behind a plain 32-bit register bus (address, write strobe, write data, read strobe, read data). It holds one output-enable bit and one output data bit per pin. It drives them to the pad as an output-value vector and an output-enable vector. It also returns the pin levels after they pass through a synchronizer.

Direction is never written as a whole word. One register address turns selected pins into outputs, and a second address turns selected pins back into inputs. Output data is split into a lower and an upper half-word register. Each write to one of these carries a per-bit mask in its upper 16 bits, so software can change any subset of pins without a read-modify-write. Software can load an output value while the pin is still an input. That value is already on the pad output when the enable is set.

Top module: `gpio_mask_port`

## Requirements
- R1: A write to offset 0x00 sets the output-enable bit of every pin whose write-data bit is 1. The other enable bits keep their value.
- R2: A write to offset 0x04 clears the output-enable bit of every pin whose write-data bit is 1. The other enable bits keep their value.
- R3: A write to offset 0x08 updates pins 0 to 15 and a write to offset 0x0C updates pins 16 to 31. Write-data bit k+16 is the mask for bit k, and bit k (k = 0..15) is the new value.
- R4: A pin's output data bit whose mask bit is 0 keeps its value through a write to its half-word register.
- R5: A read at offset 0x10 returns the 32 pin levels. A change on the pins is seen on this read two clock edges later, and not before.
- R6: A read at offset 0x04 returns the output-enable vector. Reads at 0x08 and 0x0C return that half's 16 data bits in bits 15:0 and zero in bits 31:16.
- R7: The pad output value always equals the stored data, whatever the enable is. A value stored while the pin is an input is driven unchanged on the clock edge that sets its enable.
- R8: After reset, every output-enable bit and every output data bit is 0.
- R9: A write to any offset other than 0x00, 0x04, 0x08 and 0x0C changes no state, including writes to 0x10. A read from any offset other than 0x04, 0x08, 0x0C and 0x10 returns zero, and read data is zero while the read strobe is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as the read strobe |
| pin_in | input | 32 | Raw pin levels from the pads |
| pad_out | output | 32 | Output value to the pad drivers |
| pad_oe | output | 32 | Output enable to the pad drivers |

## Verification
The effect of a write is due on the enable and value outputs right after the clock edge that samples the write strobe. The bench drives on falling edges and checks at the next falling edge. Read data comes from a combinational path off the registers, so each read is checked shortly after the strobe is applied, within the same cycle. Pin input changes are applied on a falling edge and read back before the first rising edge, after one edge and after two edges. Only the last of these reads must show the new level.

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  input  logic [31:0]       pin_in,
  output logic [31:0]       pad_out,
  output logic [31:0]       pad_oe
);

  localparam int HALF = 16;
  localparam logic [ADDR_W-1:0] OFS_OE_SET = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] OFS_OE_CLR = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] OFS_OUT_LO = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] OFS_OUT_HI = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] OFS_PINS   = ADDR_W'(8'h10);

  logic [31:0] oe_q;
  logic [31:0] dout_q;
  logic [SYNC_STAGES-1:0][31:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      oe_q <= '0;
    else if (bus_wr && bus_addr == OFS_OE_SET)
      oe_q <= oe_q | bus_wdata;
    else if (bus_wr && bus_addr == OFS_OE_CLR)
      oe_q <= oe_q & ~bus_wdata;
  end

  for (genvar h = 0; h < 2; h++) begin : g_half
    localparam logic [ADDR_W-1:0] OFS = (h == 0) ? OFS_OUT_LO : OFS_OUT_HI;
    wire [HALF-1:0] msk = bus_wdata[2*HALF-1:HALF];
    wire [HALF-1:0] val = bus_wdata[HALF-1:0];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        dout_q[h*HALF +: HALF] <= '0;
      else if (bus_wr && bus_addr == OFS)
        dout_q[h*HALF +: HALF] <= (dout_q[h*HALF +: HALF] & ~msk) | (val & msk);
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        sync_q[s] <= '0;
      else if (s == 0)
        sync_q[s] <= pin_in;
      else
        sync_q[s] <= sync_q[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        OFS_OE_CLR: bus_rdata = oe_q;
        OFS_OUT_LO: bus_rdata = {16'h0, dout_q[HALF-1:0]};
        OFS_OUT_HI: bus_rdata = {16'h0, dout_q[2*HALF-1:HALF]};
        OFS_PINS:   bus_rdata = sync_q[SYNC_STAGES-1];
        default:    bus_rdata = '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = oe_q;

  // R1
  oe_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OE_SET) |=> ((pad_oe & $past(bus_wdata)) == $past(bus_wdata)));

  // R2
  oe_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OE_CLR) |=> ((pad_oe & $past(bus_wdata)) == 32'h0));

  // R4
  lo_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT_LO) |=>
      (((pad_out[15:0] ^ $past(pad_out[15:0])) & ~$past(bus_wdata[31:16])) == 16'h0) && $stable(pad_out[31:16]));

  // R4
  hi_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_OUT_HI) |=>
      (((pad_out[31:16] ^ $past(pad_out[31:16])) & ~$past(bus_wdata[31:16])) == 16'h0) && $stable(pad_out[15:0]));

  // R7
  preload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && (bus_addr == OFS_OE_SET || bus_addr == OFS_OE_CLR)) |=> $stable(pad_out));

  // R9
  undef_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr != OFS_OE_SET && bus_addr != OFS_OE_CLR &&
     bus_addr != OFS_OUT_LO && bus_addr != OFS_OUT_HI) |=> ($stable(pad_oe) && $stable(pad_out)));

  // R9
  idle_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> (bus_rdata == 32'h0));

endmodule

// File: tb/sim_gpio_mask_port.sv
`timescale 1ns/1ps
module sim_gpio_mask_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] pin_in = '0;
  logic [31:0] pad_out;
  logic [31:0] pad_oe;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_mask_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .pin_in(pin_in), .pad_out(pad_out), .pad_oe(pad_oe)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R8 oe", pad_oe, 32'h0);
    check("R8 out", pad_out, 32'h0);
    rd(8'h04, d); check("R8 oe read", d, 32'h0);
  endtask

  task automatic t_direction;
    logic [31:0] d;
    wr(8'h00, 32'h8000_00F1);
    check("R1 set", pad_oe, 32'h8000_00F1);
    wr(8'h00, 32'h0001_0000);
    check("R1 set keeps others", pad_oe, 32'h8001_00F1);
    wr(8'h04, 32'h0000_0031);
    check("R2 clear", pad_oe, 32'h8001_00C0);
    rd(8'h04, d); check("R6 oe read", d, 32'h8001_00C0);
    wr(8'h04, 32'hFFFF_FFFF);
    check("R2 clear all", pad_oe, 32'h0);
  endtask

  task automatic t_masked;
    logic [31:0] d;
    wr(8'h08, 32'hFFFF_A5A5);
    check("R3 lo write", pad_out, 32'h0000_A5A5);
    wr(8'h0C, 32'h00FF_1234);
    check("R3 hi write", pad_out, 32'h0034_A5A5);
    wr(8'h08, 32'h000F_FFFF);
    check("R4 lo partial mask", pad_out, 32'h0034_A5AF);
    wr(8'h0C, 32'h0000_FFFF);
    check("R4 zero mask", pad_out, 32'h0034_A5AF);
    rd(8'h08, d); check("R6 lo read", d, 32'h0000_A5AF);
    rd(8'h0C, d); check("R6 hi read", d, 32'h0000_0034);
  endtask

  task automatic t_preload;
    wr(8'h0C, 32'h8000_8000);
    check("R7 value before enable", pad_out[31], 1'b1);
    check("R7 still input", pad_oe[31], 1'b0);
    wr(8'h00, 32'h8000_0000);
    check("R7 driven on enable", {pad_oe[31], pad_out[31]}, 32'h3);
    check("R7 out unchanged", pad_out, 32'h8034_A5AF);
  endtask

  task automatic t_inputs;
    logic [31:0] d;
    @(negedge clk);
    pin_in = 32'hDEAD_BEEF;
    rd(8'h10, d); check("R5 before edges", d, 32'h0);
    @(negedge clk);
    rd(8'h10, d); check("R5 one edge", d, 32'h0);
    @(negedge clk);
    rd(8'h10, d); check("R5 two edges", d, 32'hDEAD_BEEF);
    pin_in = 32'h0F0F_0001;
    repeat (2) @(negedge clk);
    rd(8'h10, d); check("R5 second pattern", d, 32'h0F0F_0001);
  endtask

  task automatic t_undefined;
    logic [31:0] d;
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h80, 32'hFFFF_0000);
    check("R9 oe untouched", pad_oe, 32'h8000_0000);
    check("R9 out untouched", pad_out, 32'h8034_A5AF);
    rd(8'h00, d); check("R9 read 0x00", d, 32'h0);
    rd(8'h18, d); check("R9 read 0x18", d, 32'h0);
    @(negedge clk);
    bus_addr = 8'h04; #1;
    check("R9 no strobe", bus_rdata, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direction();
    t_masked();
    t_preload();
    t_inputs();
    t_undefined();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++; nbad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule